// File: doc/BRIEF.md
# System Management Interrupt Gating Unit

This block gathers system-management events from eight sources and turns them into a single active-low interrupt output toward the processor. The sources are a command-port write strobe, an external interrupt request pin, the terminal-count pulse of a countdown timer, two interrupt request lines (line 12 and line 8), and three generic hardware event inputs. Each source has an enable bit. A rising edge on an enabled source sets a sticky status bit. The status bit stays set until software clears it by writing a one to it.

A global gate bit controls only the output. Events are recorded whether the gate is open or closed. An event that arrives while the gate is closed therefore stays pending, and the output asserts as soon as software opens the gate. Nothing in the block depends on the power state. A small register port gives access to the enable, status and gate bits. Reads are registered and have a latency of one cycle.

Top module: `smi_gate_unit`

## Requirements
- R1: After synchronous reset, the enable bits, status bits and gate are all 0, and `smi_n_o` is high.
- R2: Address 0 is the 16-bit enable register. Its bit positions are: bit 7 command-port write, bit 6 external request, bit 5 timer terminal count, bit 4 interrupt line 12, bit 3 interrupt line 8, and bits 2:0 generic events 2:0. Bits 15:8 are reserved and always read 0.
- R3: A status bit at address 1, in the same bit position as its enable bit, sets on a rising edge of its source while that enable bit is 1. A source held high sets its status bit once per edge, not again while the level stays high.
- R4: An edge on a source whose enable bit is 0 leaves its status bit unchanged.
- R5: A status bit stays set until software writes 1 to that bit position at address 1. Writing 0 has no effect. If a new edge arrives in the same cycle as the clear, the set wins.
- R6: Address 2 holds the gate in bit 0. Its other bits read 0.
- R7: `smi_n_o` is a registered output. It is low in the cycle after one in which the gate is 1 and any status bit with its enable bit set is 1. Otherwise it is high.
- R8: While the gate is 0, events are still recorded and `smi_n_o` stays high. Opening the gate with an event pending drives `smi_n_o` low one cycle later.
- R9: `reg_rdata_o` shows the register selected by `reg_addr_i` one cycle after the address is presented. Address 3 reads 0.
- R10: Clearing an enable bit removes that bit's status from the output condition, but the status bit itself stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command-port write strobe |
| ext_smi_i | input | 1 | External interrupt request pin |
| tmr_tc_i | input | 1 | Countdown timer terminal-count pulse |
| irq12_i | input | 1 | Interrupt request line 12 |
| irq8_i | input | 1 | Interrupt request line 8 |
| gen_evt_i | input | 3 | Generic hardware event inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| smi_n_o | output | 1 | Active-low interrupt output |

## Verification
A status bit that is lost or set by mistake shows up at `smi_n_o` two cycles after the source edge, provided the gate is open and the bit is enabled. When the gate is closed, the same fault appears only through a status read, or in the cycle after the gate opens. A wrong enable or gate bit appears in the read data one cycle after its address is presented. Long runs with random writes, clears and source edges compare the output and the read data every cycle against a bench-side model. This catches divergence within one or two cycles.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd2;
  localparam int GATE_BIT = 0;
endpackage

// File: rtl/smi_edge_capture.sv
module smi_edge_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_q;
    always_ff @(posedge clk) begin
      if (rst)                      st_q <= 1'b0;
      else if (rise_i[i] && en_i[i]) st_q <= 1'b1;
      else if (clr_i[i])            st_q <= 1'b0;
    end
    assign stat_o[i] = st_q;
  end
endmodule

// File: rtl/smi_regfile.sv
module smi_regfile
  import smi_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      stat_i,
  output logic [N-1:0]      en_o,
  output logic              gate_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - N;

  logic [N-1:0]      en_q;
  logic              gate_q;
  logic [DATA_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      gate_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_EN)  en_q   <= wdata_i[N-1:0];
      if (addr_i == ADDR_CTL) gate_q <= wdata_i[GATE_BIT];
    end
  end

  assign clr_o = (wr_i && addr_i == ADDR_STAT) ? wdata_i[N-1:0] : '0;

  always_comb begin
    rd_d = '0;
    case (addr_i)
      ADDR_EN:   rd_d = {{PAD_W{1'b0}}, en_q};
      ADDR_STAT: rd_d = {{PAD_W{1'b0}}, stat_i};
      ADDR_CTL:  rd_d[GATE_BIT] = gate_q;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end

  assign en_o   = en_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/smi_gate_unit.sv
module smi_gate_unit
  import smi_pkg::*;
#(
  parameter int N_GEN  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_i,
  input  logic              ext_smi_i,
  input  logic              tmr_tc_i,
  input  logic              irq12_i,
  input  logic              irq8_i,
  input  logic [N_GEN-1:0]  gen_evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              smi_n_o
);
  localparam int N = N_GEN + 5;

  logic [N-1:0] src_vec;
  logic [N-1:0] rise;
  logic [N-1:0] en_q;
  logic [N-1:0] stat_q;
  logic [N-1:0] clr;
  logic         gate_q;

  // Bit order fixes the register layout seen by software
  assign src_vec = {cmd_wr_i, ext_smi_i, tmr_tc_i, irq12_i, irq8_i, gen_evt_i};

  smi_edge_capture #(.N(N)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_vec),
    .rise_o (rise)
  );

  smi_status_bank #(.N(N)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .en_i   (en_q),
    .clr_i  (clr),
    .stat_o (stat_q)
  );

  smi_regfile #(.N(N), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat_q),
    .en_o    (en_q),
    .gate_o  (gate_q),
    .clr_o   (clr),
    .rdata_o (reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) smi_n_o <= 1'b1;
    else     smi_n_o <= ~(gate_q && |(stat_q & en_q));
  end
endmodule

// File: rtl/smi_gate_checker.sv
module smi_gate_checker
  import smi_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              gate_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      stat_q,
  input logic              smi_n_o
);
  p_gate_closed_r8: assert property (@(posedge clk) disable iff (rst)
    !gate_q |=> smi_n_o);

  p_pending_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (gate_q && |(stat_q & en_q)) |=> !smi_n_o);

  p_nothing_enabled_r10: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & en_q)) |=> smi_n_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && reg_addr_i == ADDR_STAT) |=>
      ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_no_set_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));
endmodule

bind smi_gate_unit smi_gate_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .gate_q     (gate_q),
  .en_q       (en_q),
  .stat_q     (stat_q),
  .smi_n_o    (smi_n_o)
);

// File: tb/smi_gate_unit_test.sv
`timescale 1ns/1ps
module smi_gate_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        smi_n;

  int tests = 0;
  int fails = 0;

  logic [7:0] en_m, st_m, prev_m;
  logic       gate_m;

  always #4 clk = ~clk;

  smi_gate_unit uut (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr_i    (src[7]),
    .ext_smi_i   (src[6]),
    .tmr_tc_i    (src[5]),
    .irq12_i     (src[4]),
    .irq8_i      (src[3]),
    .gen_evt_i   (src[2:0]),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .smi_n_o     (smi_n)
  );

  function automatic logic exp_smi_n();
    return ~(gate_m && |(st_m & en_m));
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {8'h00, en_m};
      2'd1:    return {8'h00, st_m};
      2'd2:    return {15'b0, gate_m};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input logic [7:0] s, input logic wr, input logic [1:0] a,
                      input logic [15:0] wd, input string tag);
    logic        e_smi;
    logic [15:0] e_rd;
    logic [7:0]  rise, clr;
    src = s; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    e_smi = exp_smi_n();
    e_rd  = exp_read(a);
    rise  = s & ~prev_m;
    clr   = (wr && a == 2'd1) ? wd[7:0] : 8'h00;
    st_m  = (st_m & ~clr) | (rise & en_m);
    if (wr && a == 2'd0) en_m = wd[7:0];
    if (wr && a == 2'd2) gate_m = wd[0];
    prev_m = s;
    @(posedge clk);
    @(negedge clk);
    check({tag, " smi_n R7"}, {15'b0, smi_n}, {15'b0, e_smi});
    check({tag, " rdata R9"}, reg_rdata, e_rd);
  endtask

  initial begin
    int unsigned seed = 32'd5150;
    void'($urandom(seed));
    en_m = '0; st_m = '0; prev_m = '0; gate_m = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 smi_n after reset", {15'b0, smi_n}, 16'h0001);
    step(8'h00, 0, 2'd0, 16'h0, "R1 enable");
    step(8'h00, 0, 2'd1, 16'h0, "R1 status");
    step(8'h00, 0, 2'd2, 16'h0, "R1 gate");
    // R2: reserved enable bits read 0
    step(8'h00, 1, 2'd0, 16'hFFFF, "R2 write");
    step(8'h00, 0, 2'd0, 16'h0, "R2 read");
    check("R2 reserved bits", reg_rdata & 16'hFF00, 16'h0000);
    // R8: event with gate closed, recorded but silent
    step(8'h40, 0, 2'd1, 16'h0, "R8 ext edge");
    step(8'h00, 0, 2'd1, 16'h0, "R8 pending");
    check("R8 recorded", reg_rdata, 16'h0040);
    step(8'h00, 0, 2'd1, 16'h0, "R8 gate closed");
    check("R8 output masked", {15'b0, smi_n}, 16'h0001);
    step(8'h00, 1, 2'd2, 16'h0001, "R8 open gate");
    step(8'h00, 0, 2'd2, 16'h0, "R8 fires");
    check("R8 smi asserted", {15'b0, smi_n}, 16'h0000);
    // R5: write 0 no effect, write 1 clears
    step(8'h00, 1, 2'd1, 16'h0000, "R5 write zero");
    step(8'h00, 0, 2'd1, 16'h0, "R5 still set");
    check("R5 sticky", reg_rdata, 16'h0040);
    step(8'h00, 1, 2'd1, 16'h0040, "R5 clear");
    step(8'h00, 0, 2'd1, 16'h0, "R5 cleared");
    step(8'h00, 0, 2'd1, 16'h0, "R5 idle");
    check("R5 cleared", reg_rdata, 16'h0000);
    // R4: disabled irq8 edge ignored
    step(8'h00, 1, 2'd0, 16'h00F7, "R4 disable irq8");
    step(8'h08, 0, 2'd1, 16'h0, "R4 irq8 edge");
    step(8'h00, 0, 2'd1, 16'h0, "R4 read");
    check("R4 no status", reg_rdata, 16'h0000);
    // R3: level held high sets once
    step(8'h10, 0, 2'd1, 16'h0, "R3 irq12 rise");
    step(8'h10, 1, 2'd1, 16'h0010, "R3 clear while high");
    step(8'h10, 0, 2'd1, 16'h0, "R3 held");
    step(8'h10, 0, 2'd1, 16'h0, "R3 read");
    check("R3 no re-set on level", reg_rdata, 16'h0000);
    // R5: set wins over same-cycle clear
    step(8'h00, 0, 2'd1, 16'h0, "R5 drop");
    step(8'h20, 1, 2'd1, 16'h0020, "R5 set vs clear");
    step(8'h00, 0, 2'd1, 16'h0, "R5 read");
    check("R5 set wins", reg_rdata, 16'h0020);
    // R10: disable masks output but keeps status
    step(8'h00, 1, 2'd0, 16'h0000, "R10 disable all");
    step(8'h00, 0, 2'd1, 16'h0, "R10 read");
    step(8'h00, 0, 2'd1, 16'h0, "R10 settle");
    check("R10 output high", {15'b0, smi_n}, 16'h0001);
    check("R10 status kept", reg_rdata, 16'h0020);
    // R6 and R9: gate register width and unused address
    step(8'h00, 1, 2'd2, 16'hFFFE, "R6 write");
    step(8'h00, 0, 2'd2, 16'h0, "R6 read");
    check("R6 gate only bit0", reg_rdata, 16'h0000);
    step(8'h00, 1, 2'd3, 16'hFFFF, "R9 addr3 write");
    step(8'h00, 0, 2'd3, 16'h0, "R9 addr3 read");
    check("R9 addr3 zero", reg_rdata, 16'h0000);
    // random mix, every cycle checked against model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  s;
      logic        w;
      logic [1:0]  a;
      logic [15:0] d;
      s = 8'($urandom) & 8'($urandom);
      w = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = 16'($urandom);
      step(s, w, a, d, "R3 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule